// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory subsystem from reset to an operational state with no processor involved. After a start pulse it walks a fixed script of register writes toward the memory controller and its PHY. It turns on the PHY clock, resets the PHY and launches calibration, and replays the twelve DDR2 mode-register commands that the memory standard expects. It then loads the controller's timing, latency and configuration registers and raises a sticky done flag.

All writes leave through one register-write port made of address, data and a valid strobe. Each write is held stable until the receiver returns ready. A programmable quiet interval separates the steps that need settling time. The interval is counted from the cycle in which the write was accepted, so a slow receiver never shortens it. Register addresses, command codes, argument bits, field positions, the delay length and the values loaded at the end are all parameters. A simulation can therefore run with a short delay.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset `wr_valid`, `busy` and `done` are 0, and nothing is written until `start` is seen high at a clock edge; `wr_ready` has no effect while idle.
- R2: After the start edge exactly `WAIT_CYCLES` cycles pass with `wr_valid` low, then the first write goes to the PHY config address (default 8'h10) with only the enable bit (default bit 0) set.
- R3: The second write goes to the PHY control address (default 8'h14) with the PHY reset bit (bit 0) and calibration reset bit (bit 1) set, value 3. The third write goes to the same address in the cycle right after the second is accepted, with only the calibration start bit (bit 2) set, value 4.
- R4: Each memory command is one write to the command address (default 8'h20) carrying the 8-bit code in bits 23:16, the 16-bit argument in bits 15:0, and zeros in bits 31:24.
- R5: Exactly eighteen writes are made, and the twelve commands come in this order (default codes in brackets): deselect [07] arg 0; precharge [02] all-banks arg 16'h0400; extended mode 2 [0A] arg 0; extended mode 3 [0B] arg 0; extended mode [09] DLL-enable 16'h0040; mode [08] DLL-reset 16'h0100; precharge [02] 16'h0400; refresh [01] 0; refresh [01] 0; mode [08]; extended mode [09]; extended mode [09].
- R6: The tenth command's argument equals `MODE_WORD[15:0]`. The eleventh carries OCD-default (16'h0380) OR DLL-enable. The twelfth carries OCD-exit (16'h0000) OR DLL-enable OR `MODE_WORD[31:16]`.
- R7: A quiet gap of exactly `WAIT_CYCLES` cycles with `wr_valid` low follows the acceptance of the PHY config write, of the calibration start write and of every one of the twelve commands, including the last.
- R8: After the last command's gap, the timing (8'h24), latency (8'h28) and configuration (8'h2C) registers are written with `TIMING_VAL`, `LATENCY_VAL` and `CONFIG_VAL`. Each follows the previous acceptance with no gap.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R10: `busy` is high from the cycle after start until the configuration write is accepted. `done` then rises in the next cycle and stays high until reset. `start` is ignored while busy or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the sequence when idle |
| wr_ready | input | 1 | Receiver accepts the presented write |
| wr_valid | output | 1 | A register write is presented |
| wr_addr | output | ADDR_W | Register address of the write |
| wr_data | output | DATA_W | Register value of the write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, sticky until reset |

## Verification
A wrong step index appears on the port at the next presented write, as a wrong address or data word, or as a gap where none belongs. A wrong delay count shows up as a quiet interval one or more cycles off, which the per-cycle comparison flags on the first cycle where `wr_valid` disagrees. A corrupt handshake state shows up within one stalled cycle as a moved address or data word, or as a strobe that drops without `wr_ready`. The bench varies the ready pattern (always ready, light stalls, long stalls), restarts from a mid-sequence reset, and pokes `start` while busy and after done.

// File: rtl/ddr2_init_pkg.sv
// Shared constants and types for the DDR2 initialization sequencer.
// Assumes a fixed script: three PHY writes, twelve commands, three final loads.
package ddr2_init_pkg;
    localparam int PHY_STEPS  = 3;
    localparam int NUM_CMDS   = 12;
    localparam int LOAD_STEPS = 3;
    localparam int NUM_STEPS  = PHY_STEPS + NUM_CMDS + LOAD_STEPS;
    localparam int STEP_W     = $clog2(NUM_STEPS + 1);
    localparam int FIRST_CMD  = PHY_STEPS;
    localparam int FIRST_LOAD = PHY_STEPS + NUM_CMDS;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_WRITE = 2'd2,
        SQ_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/ddr2_init_delay.sv
// Quiet-interval timer. A load pulse arms it. Exactly WAIT_CYCLES cycles
// later 'expired' is high for one cycle. Assumes WAIT_CYCLES >= 1.
module ddr2_init_delay #(
    parameter int WAIT_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    logic             running;
    logic [CNT_W-1:0] remain;

    // Count the interval down from the load cycle and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            remain  <= '0;
        end else if (load) begin
            running <= 1'b1;
            remain  <= LAST;
        end else if (running) begin
            if (remain == '0) running <= 1'b0;
            else              remain  <= remain - 1'b1;
        end
    end

    assign expired = running && (remain == '0);

    assert_single_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> !expired);
endmodule

// File: rtl/ddr2_init_script.sv
// Combinational script table. Maps a step number to the register address,
// the data word and whether a quiet interval must come before the step.
// Assumes step numbers 0..NUM_STEPS-1. Out-of-range steps return zeros.
module ddr2_init_script
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CODE_W = 8,
    parameter int ARG_W  = 16,
    parameter int CODE_LSB = 16,
    parameter int ARG_LSB  = 0,
    parameter logic [ADDR_W-1:0] ADDR_PHY_CFG  = 8'h10,
    parameter logic [ADDR_W-1:0] ADDR_PHY_CTRL = 8'h14,
    parameter logic [ADDR_W-1:0] ADDR_CMD      = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_TIMING   = 8'h24,
    parameter logic [ADDR_W-1:0] ADDR_LATENCY  = 8'h28,
    parameter logic [ADDR_W-1:0] ADDR_CONFIG   = 8'h2C,
    parameter int PHY_EN_BIT    = 0,
    parameter int PHY_RST_BIT   = 0,
    parameter int CAL_RST_BIT   = 1,
    parameter int CAL_START_BIT = 2,
    parameter logic [CODE_W-1:0] CODE_DESEL = 8'h07,
    parameter logic [CODE_W-1:0] CODE_PRE   = 8'h02,
    parameter logic [CODE_W-1:0] CODE_EMR2  = 8'h0A,
    parameter logic [CODE_W-1:0] CODE_EMR3  = 8'h0B,
    parameter logic [CODE_W-1:0] CODE_EMR   = 8'h09,
    parameter logic [CODE_W-1:0] CODE_MR    = 8'h08,
    parameter logic [CODE_W-1:0] CODE_REF   = 8'h01,
    parameter logic [ARG_W-1:0]  ARG_PRE_ALL  = 16'h0400,
    parameter logic [ARG_W-1:0]  ARG_DLL_EN   = 16'h0040,
    parameter logic [ARG_W-1:0]  ARG_DLL_RST  = 16'h0100,
    parameter logic [ARG_W-1:0]  ARG_OCD_DFLT = 16'h0380,
    parameter logic [ARG_W-1:0]  ARG_OCD_EXIT = 16'h0000,
    parameter logic [2*ARG_W-1:0] MODE_WORD   = 32'h0002_0642,
    parameter logic [DATA_W-1:0] TIMING_VAL   = 32'h1234_5678,
    parameter logic [DATA_W-1:0] LATENCY_VAL  = 32'h0000_0003,
    parameter logic [DATA_W-1:0] CONFIG_VAL   = 32'h0000_00A5
) (
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              wait_before
);
    localparam logic [ARG_W-1:0] MODE_LO = MODE_WORD[ARG_W-1:0];
    localparam logic [ARG_W-1:0] MODE_HI = MODE_WORD[2*ARG_W-1:ARG_W];

    logic [CODE_W-1:0] code;
    logic [ARG_W-1:0]  arg;
    int                s;

    // Pick the command code and argument for a step in the command list.
    always_comb begin
        s    = int'(step);
        code = '0;
        arg  = '0;
        case (s - FIRST_CMD)
            0:  begin code = CODE_DESEL; arg = '0;                                   end
            1:  begin code = CODE_PRE;   arg = ARG_PRE_ALL;                          end
            2:  begin code = CODE_EMR2;  arg = '0;                                   end
            3:  begin code = CODE_EMR3;  arg = '0;                                   end
            4:  begin code = CODE_EMR;   arg = ARG_DLL_EN;                           end
            5:  begin code = CODE_MR;    arg = ARG_DLL_RST;                          end
            6:  begin code = CODE_PRE;   arg = ARG_PRE_ALL;                          end
            7:  begin code = CODE_REF;   arg = '0;                                   end
            8:  begin code = CODE_REF;   arg = '0;                                   end
            9:  begin code = CODE_MR;    arg = MODE_LO;                              end
            10: begin code = CODE_EMR;   arg = ARG_OCD_DFLT | ARG_DLL_EN;            end
            11: begin code = CODE_EMR;   arg = ARG_OCD_EXIT | ARG_DLL_EN | MODE_HI;  end
            default: begin code = '0; arg = '0; end
        endcase
    end

    // Build the address and data word for the selected step.
    always_comb begin
        addr        = '0;
        data        = '0;
        wait_before = 1'b0;
        if (s == 0) begin
            addr = ADDR_PHY_CFG;
            data[PHY_EN_BIT] = 1'b1;
            wait_before = 1'b1;
        end else if (s == 1) begin
            addr = ADDR_PHY_CTRL;
            data[PHY_RST_BIT] = 1'b1;
            data[CAL_RST_BIT] = 1'b1;
            wait_before = 1'b1;
        end else if (s == 2) begin
            addr = ADDR_PHY_CTRL;
            data[CAL_START_BIT] = 1'b1;
        end else if (s < FIRST_LOAD) begin
            addr = ADDR_CMD;
            data[CODE_LSB +: CODE_W] = code;
            data[ARG_LSB +: ARG_W]   = arg;
            wait_before = 1'b1;
        end else if (s == FIRST_LOAD) begin
            addr = ADDR_TIMING;
            data = TIMING_VAL;
            wait_before = 1'b1;
        end else if (s == FIRST_LOAD + 1) begin
            addr = ADDR_LATENCY;
            data = LATENCY_VAL;
        end else if (s == FIRST_LOAD + 2) begin
            addr = ADDR_CONFIG;
            data = CONFIG_VAL;
        end
    end
endmodule

// File: rtl/ddr2_init_port.sv
// Register-write port. It captures a write on 'issue' and presents it until
// 'ready'. An issue in the cycle of an acceptance replaces the write back
// to back. Assumes the sequencer issues only when no write is pending, or
// in the same cycle the pending one is accepted.
module ddr2_init_port #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic              ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              accepted
);
    assign accepted = wr_valid && ready;

    // Hold the presented write until accepted; load a new one on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (issue) begin
            wr_valid <= 1'b1;
            wr_addr  <= nxt_addr;
            wr_data  <= nxt_data;
        end else if (accepted) begin
            wr_valid <= 1'b0;
        end
    end

    assert_hold_until_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    assert_no_issue_over_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && wr_valid) |-> ready);
endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up initialization sequencer (top). A start pulse walks the
// script: PHY clock on, PHY reset and calibration, twelve mode commands,
// then timing/latency/config loads, with quiet intervals where the script
// asks. Assumes WAIT_CYCLES >= 1 and a receiver that eventually raises ready.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int WAIT_CYCLES = 10000,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CODE_W = 8,
    parameter int ARG_W  = 16,
    parameter int CODE_LSB = 16,
    parameter int ARG_LSB  = 0,
    parameter logic [ADDR_W-1:0] ADDR_PHY_CFG  = 8'h10,
    parameter logic [ADDR_W-1:0] ADDR_PHY_CTRL = 8'h14,
    parameter logic [ADDR_W-1:0] ADDR_CMD      = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_TIMING   = 8'h24,
    parameter logic [ADDR_W-1:0] ADDR_LATENCY  = 8'h28,
    parameter logic [ADDR_W-1:0] ADDR_CONFIG   = 8'h2C,
    parameter int PHY_EN_BIT    = 0,
    parameter int PHY_RST_BIT   = 0,
    parameter int CAL_RST_BIT   = 1,
    parameter int CAL_START_BIT = 2,
    parameter logic [CODE_W-1:0] CODE_DESEL = 8'h07,
    parameter logic [CODE_W-1:0] CODE_PRE   = 8'h02,
    parameter logic [CODE_W-1:0] CODE_EMR2  = 8'h0A,
    parameter logic [CODE_W-1:0] CODE_EMR3  = 8'h0B,
    parameter logic [CODE_W-1:0] CODE_EMR   = 8'h09,
    parameter logic [CODE_W-1:0] CODE_MR    = 8'h08,
    parameter logic [CODE_W-1:0] CODE_REF   = 8'h01,
    parameter logic [ARG_W-1:0]  ARG_PRE_ALL  = 16'h0400,
    parameter logic [ARG_W-1:0]  ARG_DLL_EN   = 16'h0040,
    parameter logic [ARG_W-1:0]  ARG_DLL_RST  = 16'h0100,
    parameter logic [ARG_W-1:0]  ARG_OCD_DFLT = 16'h0380,
    parameter logic [ARG_W-1:0]  ARG_OCD_EXIT = 16'h0000,
    parameter logic [2*ARG_W-1:0] MODE_WORD   = 32'h0002_0642,
    parameter logic [DATA_W-1:0] TIMING_VAL   = 32'h1234_5678,
    parameter logic [DATA_W-1:0] LATENCY_VAL  = 32'h0000_0003,
    parameter logic [DATA_W-1:0] CONFIG_VAL   = 32'h0000_00A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
    localparam int UPPER_LSB = CODE_LSB + CODE_W;

    seq_state_e        state, state_n;
    logic [STEP_W-1:0] idx, idx_n, sel;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic              s_wait;
    logic              issue, dly_load, expired, accepted;

    // The step looked up is the current one while waiting, the next while writing.
    assign sel = (state == SQ_WRITE) ? idx + STEP_W'(1) : idx;

    ddr2_init_script #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .ARG_W(ARG_W),
        .CODE_LSB(CODE_LSB), .ARG_LSB(ARG_LSB),
        .ADDR_PHY_CFG(ADDR_PHY_CFG), .ADDR_PHY_CTRL(ADDR_PHY_CTRL),
        .ADDR_CMD(ADDR_CMD), .ADDR_TIMING(ADDR_TIMING),
        .ADDR_LATENCY(ADDR_LATENCY), .ADDR_CONFIG(ADDR_CONFIG),
        .PHY_EN_BIT(PHY_EN_BIT), .PHY_RST_BIT(PHY_RST_BIT),
        .CAL_RST_BIT(CAL_RST_BIT), .CAL_START_BIT(CAL_START_BIT),
        .CODE_DESEL(CODE_DESEL), .CODE_PRE(CODE_PRE), .CODE_EMR2(CODE_EMR2),
        .CODE_EMR3(CODE_EMR3), .CODE_EMR(CODE_EMR), .CODE_MR(CODE_MR),
        .CODE_REF(CODE_REF), .ARG_PRE_ALL(ARG_PRE_ALL), .ARG_DLL_EN(ARG_DLL_EN),
        .ARG_DLL_RST(ARG_DLL_RST), .ARG_OCD_DFLT(ARG_OCD_DFLT),
        .ARG_OCD_EXIT(ARG_OCD_EXIT), .MODE_WORD(MODE_WORD),
        .TIMING_VAL(TIMING_VAL), .LATENCY_VAL(LATENCY_VAL), .CONFIG_VAL(CONFIG_VAL)
    ) u_script (
        .step(sel), .addr(s_addr), .data(s_data), .wait_before(s_wait)
    );

    ddr2_init_delay #(.WAIT_CYCLES(WAIT_CYCLES)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .expired(expired)
    );

    ddr2_init_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .issue(issue), .nxt_addr(s_addr),
        .nxt_data(s_data), .ready(wr_ready), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .accepted(accepted)
    );

    // Decide the next state, step, timer load and write issue.
    always_comb begin
        state_n  = state;
        idx_n    = idx;
        issue    = 1'b0;
        dly_load = 1'b0;
        case (state)
            SQ_IDLE: if (start) begin
                idx_n    = '0;
                dly_load = 1'b1;
                state_n  = SQ_WAIT;
            end
            SQ_WAIT: if (expired) begin
                issue   = 1'b1;
                state_n = SQ_WRITE;
            end
            SQ_WRITE: if (accepted) begin
                if (idx == LAST_STEP) begin
                    state_n = SQ_DONE;
                end else begin
                    idx_n = idx + STEP_W'(1);
                    if (s_wait) begin
                        dly_load = 1'b1;
                        state_n  = SQ_WAIT;
                    end else begin
                        issue = 1'b1;
                    end
                end
            end
            default: state_n = state;
        endcase
    end

    // Register the sequencer state and step number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            idx   <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
        end
    end

    assign busy = (state == SQ_WAIT) || (state == SQ_WRITE);
    assign done = (state == SQ_DONE);

    assert_quiet_while_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT) |-> !wr_valid);
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    assert_busy_done_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_first_write_phy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && idx == '0) |-> (wr_addr == ADDR_PHY_CFG));
    assert_cmd_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_CMD) |-> ((wr_data >> UPPER_LSB) == '0));
    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE) |-> !wr_valid);
endmodule

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 6;
    localparam logic [31:0] MODE = 32'h0006_0A53;
    localparam logic [31:0] TIM  = 32'hCAFE_0123;
    localparam logic [31:0] LAT  = 32'h0000_0005;
    localparam logic [31:0] CFG  = 32'h0000_00A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic wr_ready = 1'b0;
    logic wr_valid, busy, done;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;

    ddr2_init_seq #(.WAIT_CYCLES(W), .MODE_WORD(MODE), .TIMING_VAL(TIM),
                    .LATENCY_VAL(LAT), .CONFIG_VAL(CFG)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_ready(wr_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done));

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0, cycles = 0, dut_acc = 0, rdy_mode = 0;
    logic [7:0]  exp_addr [18];
    logic [31:0] exp_data [18];
    bit          exp_gap  [18];
    bit chk_on = 0, m_busy = 0, m_done = 0, m_valid = 0;
    int m_idx = 0, m_gap = 0;
    bit stalled = 0;
    logic [7:0] st_addr; logic [31:0] st_data;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [31:0] cmd(input logic [7:0] c, input logic [15:0] a);
        return {8'h00, c, a};
    endfunction

    function automatic string req_of(input int i);
        if (i == 0) return "R2";
        if (i <= 2) return "R3";
        if (i == 12 || i == 13 || i == 14) return "R6";
        if (i < 15) return "R5";
        return "R8";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Expected script built from the requirements.
    initial begin
        exp_addr[0] = 8'h10; exp_data[0] = 32'h1;  exp_gap[0] = 1;
        exp_addr[1] = 8'h14; exp_data[1] = 32'h3;  exp_gap[1] = 1;
        exp_addr[2] = 8'h14; exp_data[2] = 32'h4;  exp_gap[2] = 0;
        exp_data[3]  = cmd(8'h07, 16'h0000);
        exp_data[4]  = cmd(8'h02, 16'h0400);
        exp_data[5]  = cmd(8'h0A, 16'h0000);
        exp_data[6]  = cmd(8'h0B, 16'h0000);
        exp_data[7]  = cmd(8'h09, 16'h0040);
        exp_data[8]  = cmd(8'h08, 16'h0100);
        exp_data[9]  = cmd(8'h02, 16'h0400);
        exp_data[10] = cmd(8'h01, 16'h0000);
        exp_data[11] = cmd(8'h01, 16'h0000);
        exp_data[12] = cmd(8'h08, MODE[15:0]);
        exp_data[13] = cmd(8'h09, 16'h0380 | 16'h0040);
        exp_data[14] = cmd(8'h09, 16'h0000 | 16'h0040 | MODE[31:16]);
        for (int i = 3; i < 15; i++) begin exp_addr[i] = 8'h20; exp_gap[i] = 1; end
        exp_addr[15] = 8'h24; exp_data[15] = TIM; exp_gap[15] = 1;
        exp_addr[16] = 8'h28; exp_data[16] = LAT; exp_gap[16] = 0;
        exp_addr[17] = 8'h2C; exp_data[17] = CFG; exp_gap[17] = 0;
    end

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (wr_valid === 1'b1 && wr_ready) begin
            dut_acc++;
            if (wr_addr == 8'h20)
                chk(wr_data[31:24] == 8'h00, "R4", {24'h0, wr_data[31:24]}, 32'h0);
        end
        stalled = (wr_valid === 1'b1) && !wr_ready;
        st_addr = wr_addr; st_data = wr_data;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_valid = 0; m_idx = 0; m_gap = 0;
        end else if (!m_busy && !m_done) begin
            if (start) begin m_busy = 1; m_idx = 0; m_gap = W; m_valid = 0; end
        end else if (m_busy && !m_valid) begin
            m_gap--;
            if (m_gap == 0) m_valid = 1;
        end else if (m_busy && m_valid && wr_ready) begin
            if (m_idx == 17) begin m_busy = 0; m_done = 1; m_valid = 0; end
            else begin
                m_idx++;
                if (exp_gap[m_idx]) begin m_valid = 0; m_gap = W; end
            end
        end
    end

    // Compare the ports with the model on every falling edge.
    always @(negedge clk) begin
        if (chk_on) begin
            chk(wr_valid === m_valid, "R7", {31'h0, wr_valid}, {31'h0, m_valid});
            if (m_valid) begin
                chk(wr_addr === exp_addr[m_idx], req_of(m_idx), {24'h0, wr_addr}, {24'h0, exp_addr[m_idx]});
                chk(wr_data === exp_data[m_idx], req_of(m_idx), wr_data, exp_data[m_idx]);
            end
            chk(busy === m_busy, "R10", {31'h0, busy}, {31'h0, m_busy});
            chk(done === m_done, "R10", {31'h0, done}, {31'h0, m_done});
            if (stalled && rst_n)
                chk(wr_valid === 1'b1 && wr_addr === st_addr && wr_data === st_data,
                    "R9", wr_data, st_data);
        end
    end

    // Ready pattern generator: always ready, light stalls, long stalls.
    always @(negedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: wr_ready = 1'b1;
            1: wr_ready = lfsr[0] | lfsr[3];
            default: wr_ready = lfsr[0] & lfsr[5];
        endcase
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic pulse_start();
        start = 1'b1; step(1); start = 1'b0;
    endtask

    task automatic wait_done();
        while (!m_done && cycles < 100000) step(1);
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        wait (cycles > 50000);
        total++; bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=done", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(2);
        chk_on = 1;
        step(1);
        // R1: reset state, then idle with ready high does nothing.
        chk(!wr_valid && !busy && !done, "R1", {29'h0, wr_valid, busy, done}, 32'h0);
        rst_n = 1'b1; rdy_mode = 0;
        step(10);
        chk(!wr_valid && !busy && !done && dut_acc == 0, "R1", dut_acc, 0);

        // Run 1: light stalls, start poked while busy.
        rdy_mode = 1;
        pulse_start();
        step(20);
        start = 1'b1; step(3); start = 1'b0;   // R10: ignored while busy
        wait_done();
        chk(dut_acc == 18, "R5", dut_acc, 18);
        chk(done === 1'b1 && busy === 1'b0, "R10", {30'h0, busy, done}, 32'h1);
        pulse_start();                          // R10: ignored after done
        step(3 * W);
        chk(done === 1'b1 && !wr_valid && dut_acc == 18, "R10", dut_acc, 18);

        // Mid-sequence reset returns to idle (R1).
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        rdy_mode = 0; dut_acc = 0;
        pulse_start();
        step(40);
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
        chk(!wr_valid && !busy && !done, "R1", {29'h0, wr_valid, busy, done}, 32'h0);

        // Run 2: long stalls.
        dut_acc = 0; rdy_mode = 2;
        pulse_start();
        wait_done();
        chk(dut_acc == 18, "R5", dut_acc, 18);
        step(5);
        chk(done === 1'b1, "R10", {31'h0, done}, 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule